// File: doc/BRIEF.md
# Physical Register Reclamation Unit

This block manages the physical registers of an out-of-order core that renames its destination registers. It keeps a pool of free physical tags and a speculative map from architectural to physical registers. Each accepted allocation bundle receives fresh tags. For every lane the block also reports the tag that the lane's destination displaces. When an earlier lane of the same bundle writes the same architectural register, the displaced tag is the one that earlier lane was just given.

A displaced tag does not return to the pool when its mapping is overwritten, because readers of the old value may still be waiting. It returns only when the displacing instruction commits. At that moment the commit port carries the displaced tag back to the tail of the pool and writes the new tag into a committed map. Once the pipeline drains, the committed map names exactly the registers that hold architectural state, and it can be read through a dedicated port. A flush restores the speculative map from the committed map and rewinds the pool, so that every tag given to a squashed instruction becomes free again.

The allocate side is a valid/ready stream. `alloc_ready` depends combinationally on `alloc_cnt` and `flush`. A bundle transfers in a cycle where both `alloc_valid` and `alloc_ready` are high, and the grant outputs are meaningful only in that cycle. A producer that sees `alloc_ready` low holds its bundle and retries, and the block takes no part of a refused bundle. Commits must arrive in allocation order, with at most one per cycle.

Top module: `prr_reclaim_unit`

## Requirements
- R1: After reset, architectural register i maps to physical register i in the committed map. `free_count` equals the pool depth (physical count minus architectural count, 64 by default). The first tags granted are the architectural count upward, in increasing order.
- R2: An accepted bundle of `alloc_cnt` lanes gives lanes 0 to `alloc_cnt`-1 the next tags of the pool in FIFO order, lane 0 first. `alloc_new_tags` and `alloc_old_tags` are packed so that lane k occupies bits [k*TW +: TW], and `alloc_arch` packs lane k at bits [k*AW +: AW]. Lanes at or above `alloc_cnt` take nothing.
- R3: `alloc_ready` is low whenever `alloc_cnt` exceeds the lane count or exceeds `free_count`. A refused bundle changes neither the pool nor the map. `pool_empty` is high exactly when `free_count` is zero.
- R4: Each granted lane reports on `alloc_old_tags` the tag that its architectural register maps to in the speculative map before the bundle.
- R5: If an earlier lane of the same bundle names the same architectural register, the old tag of a lane is the new tag of the latest such earlier lane. After the bundle, the highest such lane's tag is the mapping.
- R6: Renaming never frees a register. `free_count` drops by the number of tags granted and does not rise on allocation.
- R7: A commit pushes `commit_old_tag` to the tail of the pool, behind every tag already free, and sets the committed map entry of `commit_arch` to `commit_new_tag` from the next cycle.
- R8: While `flush` is high, `alloc_ready` is low. After a flush, `free_count` equals the pool depth. The speculative map equals the committed map, including any commit made in the flush cycle. Tags held by squashed instructions are granted again first, in their original order.
- R9: After every in-flight instruction commits, `free_count` equals the pool depth and the committed map holds the final architectural mapping.
- R10: An allocation and a commit in the same cycle both take effect: `free_count` becomes the old count minus the granted count plus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Allocation bundle offered |
| alloc_ready | output | 1 | Bundle can be taken this cycle |
| alloc_cnt | input | CW | Number of lanes requesting a tag |
| alloc_arch | input | LANES*AW | Destination architectural register per lane |
| alloc_new_tags | output | LANES*TW | Granted physical tag per lane |
| alloc_old_tags | output | LANES*TW | Displaced physical tag per lane |
| pool_empty | output | 1 | No free tag left |
| free_count | output | PW | Number of free tags |
| commit_valid | input | 1 | Oldest in-flight instruction commits |
| commit_arch | input | AW | Its architectural destination |
| commit_new_tag | input | TW | Tag it was granted |
| commit_old_tag | input | TW | Tag it displaced, to be freed |
| flush | input | 1 | Squash all in-flight instructions |
| map_rd_arch | input | AW | Committed map read address |
| map_rd_tag | output | TW | Committed map read data |

## Verification
The assertions check on every cycle that the block never accepts a bundle larger than the pool and that an empty pool blocks any non-zero request. They also check that the granted tags within a bundle are distinct and that the free count moves by exactly the grants and commits of the previous cycle. In addition, they check that a flush stalls allocation and refills the pool, and that no commit arrives when nothing is in flight. Only the bench's scenarios can show the following: which tags are granted, the displaced tags with forwarding inside a bundle, the FIFO reuse order after commits and flushes, and the contents of the committed map after the pipeline drains.

// File: rtl/prr_pkg.sv
package prr_pkg;
  // Default sizing: 32 architectural registers, 64 extra physical tags
  // to cover roughly 50 renamed destinations in flight, 4-wide rename.
  localparam int unsigned PRR_NARCH = 32;
  localparam int unsigned PRR_NPHYS = 96;
  localparam int unsigned PRR_LANES = 4;
endpackage

// File: rtl/prr_free_fifo.sv
// Circular pool of free physical tags. The slot index of the oldest
// in-flight grant (retire pointer) always equals the push slot, because
// free + in-flight tags always fill the whole ring.
module prr_free_fifo #(
  parameter int unsigned NARCH = 32,
  parameter int unsigned NPHYS = 96,
  parameter int unsigned LANES = 4,
  localparam int unsigned DEPTH = NPHYS - NARCH,
  localparam int unsigned IW = $clog2(DEPTH),
  localparam int unsigned PW = $clog2(DEPTH + 1),
  localparam int unsigned TW = $clog2(NPHYS),
  localparam int unsigned CW = $clog2(LANES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pop_en,
  input  logic [CW-1:0]     pop_cnt,
  input  logic              push_en,
  input  logic [TW-1:0]     push_tag,
  input  logic              rewind,
  output logic [LANES*TW-1:0] peek_tags,
  output logic [PW-1:0]     free_cnt
);

  logic [TW-1:0] ring_q [DEPTH];
  logic [IW-1:0] head_q, head_d;
  logic [IW-1:0] retire_q, retire_d;
  logic [PW-1:0] free_q, free_d;

  function automatic logic [IW-1:0] ring_add(input logic [IW-1:0] base,
                                             input int unsigned inc);
    int unsigned s;
    s = int'(base) + inc;
    if (s >= DEPTH) s = s - DEPTH;
    return IW'(s);
  endfunction

  // Read-ahead of the next LANES free tags
  always_comb begin
    for (int k = 0; k < LANES; k++) begin
      peek_tags[k*TW +: TW] = ring_q[ring_add(head_q, k)];
    end
  end

  // Pointer and count next-state
  always_comb begin
    int unsigned taken;
    taken    = pop_en ? int'(pop_cnt) : 0;
    head_d   = ring_add(head_q, taken);
    retire_d = push_en ? ring_add(retire_q, 1) : retire_q;
    free_d   = PW'(int'(free_q) - taken + (push_en ? 1 : 0));
    if (rewind) begin
      head_d = retire_d;
      free_d = PW'(DEPTH);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q   <= '0;
      retire_q <= '0;
      free_q   <= PW'(DEPTH);
    end else begin
      head_q   <= head_d;
      retire_q <= retire_d;
      free_q   <= free_d;
    end
  end

  // Storage: reset loads the non-architectural tags in increasing order
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) ring_q[i] <= TW'(NARCH + i);
    end else if (push_en) begin
      ring_q[retire_q] <= push_tag;
    end
  end

  assign free_cnt = free_q;

endmodule

// File: rtl/prr_spec_map.sv
// Speculative architectural-to-physical map with in-bundle forwarding.
module prr_spec_map #(
  parameter int unsigned NARCH = 32,
  parameter int unsigned NPHYS = 96,
  parameter int unsigned LANES = 4,
  localparam int unsigned TW = $clog2(NPHYS),
  localparam int unsigned AW = $clog2(NARCH),
  localparam int unsigned CW = $clog2(LANES + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 upd_en,
  input  logic [CW-1:0]        upd_cnt,
  input  logic [LANES*AW-1:0]  upd_arch,
  input  logic [LANES*TW-1:0]  new_tags,
  input  logic                 restore,
  input  logic [NARCH*TW-1:0]  restore_map,
  output logic [LANES*TW-1:0]  old_tags
);

  logic [TW-1:0] map_q [NARCH];

  // Displaced tag per lane: table value unless an earlier active lane
  // of the same bundle writes the same register (latest one wins).
  always_comb begin
    logic [AW-1:0] ak;
    logic [TW-1:0] ot;
    for (int k = 0; k < LANES; k++) begin
      ak = upd_arch[k*AW +: AW];
      ot = map_q[ak];
      for (int j = 0; j < k; j++) begin
        if (j < int'(upd_cnt) && upd_arch[j*AW +: AW] == ak) begin
          ot = new_tags[j*TW +: TW];
        end
      end
      old_tags[k*TW +: TW] = ot;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NARCH; i++) map_q[i] <= TW'(i);
    end else if (restore) begin
      for (int i = 0; i < NARCH; i++) map_q[i] <= restore_map[i*TW +: TW];
    end else if (upd_en) begin
      // Ascending lane order: the highest lane on a register wins
      for (int k = 0; k < LANES; k++) begin
        if (k < int'(upd_cnt)) begin
          map_q[upd_arch[k*AW +: AW]] <= new_tags[k*TW +: TW];
        end
      end
    end
  end

endmodule

// File: rtl/prr_commit_map.sv
// Committed architectural-to-physical map, updated in program order.
module prr_commit_map #(
  parameter int unsigned NARCH = 32,
  parameter int unsigned NPHYS = 96,
  localparam int unsigned TW = $clog2(NPHYS),
  localparam int unsigned AW = $clog2(NARCH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [AW-1:0]       wr_arch,
  input  logic [TW-1:0]       wr_tag,
  input  logic [AW-1:0]       rd_arch,
  output logic [TW-1:0]       rd_tag,
  output logic [NARCH*TW-1:0] next_map
);

  logic [TW-1:0] cmap_q [NARCH];

  // Map as it will be after this cycle's commit (flush restore source)
  always_comb begin
    for (int i = 0; i < NARCH; i++) begin
      next_map[i*TW +: TW] = cmap_q[i];
      if (wr_en && int'(wr_arch) == i) next_map[i*TW +: TW] = wr_tag;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NARCH; i++) cmap_q[i] <= TW'(i);
    end else if (wr_en) begin
      cmap_q[wr_arch] <= wr_tag;
    end
  end

  assign rd_tag = cmap_q[rd_arch];

endmodule

// File: rtl/prr_reclaim_unit.sv
module prr_reclaim_unit
  import prr_pkg::*;
#(
  parameter int unsigned NARCH = PRR_NARCH,
  parameter int unsigned NPHYS = PRR_NPHYS,
  parameter int unsigned LANES = PRR_LANES,
  localparam int unsigned DEPTH = NPHYS - NARCH,
  localparam int unsigned TW = $clog2(NPHYS),
  localparam int unsigned AW = $clog2(NARCH),
  localparam int unsigned CW = $clog2(LANES + 1),
  localparam int unsigned PW = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                alloc_valid,
  output logic                alloc_ready,
  input  logic [CW-1:0]       alloc_cnt,
  input  logic [LANES*AW-1:0] alloc_arch,
  output logic [LANES*TW-1:0] alloc_new_tags,
  output logic [LANES*TW-1:0] alloc_old_tags,
  output logic                pool_empty,
  output logic [PW-1:0]       free_count,
  input  logic                commit_valid,
  input  logic [AW-1:0]       commit_arch,
  input  logic [TW-1:0]       commit_new_tag,
  input  logic [TW-1:0]       commit_old_tag,
  input  logic                flush,
  input  logic [AW-1:0]       map_rd_arch,
  output logic [TW-1:0]       map_rd_tag
);

  logic                alloc_fire;
  logic [NARCH*TW-1:0] committed_next;

  // Whole-bundle admission: refuse rather than grant partially
  assign alloc_ready = !flush
                    && int'(alloc_cnt) <= LANES
                    && int'(alloc_cnt) <= int'(free_count);
  assign alloc_fire  = alloc_valid && alloc_ready;
  assign pool_empty  = (free_count == '0);

  prr_free_fifo #(.NARCH(NARCH), .NPHYS(NPHYS), .LANES(LANES)) u_pool (
    .clk       (clk),
    .rst_n     (rst_n),
    .pop_en    (alloc_fire),
    .pop_cnt   (alloc_cnt),
    .push_en   (commit_valid),
    .push_tag  (commit_old_tag),
    .rewind    (flush),
    .peek_tags (alloc_new_tags),
    .free_cnt  (free_count)
  );

  prr_spec_map #(.NARCH(NARCH), .NPHYS(NPHYS), .LANES(LANES)) u_spec (
    .clk         (clk),
    .rst_n       (rst_n),
    .upd_en      (alloc_fire),
    .upd_cnt     (alloc_cnt),
    .upd_arch    (alloc_arch),
    .new_tags    (alloc_new_tags),
    .restore     (flush),
    .restore_map (committed_next),
    .old_tags    (alloc_old_tags)
  );

  prr_commit_map #(.NARCH(NARCH), .NPHYS(NPHYS)) u_cmap (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (commit_valid),
    .wr_arch  (commit_arch),
    .wr_tag   (commit_new_tag),
    .rd_arch  (map_rd_arch),
    .rd_tag   (map_rd_tag),
    .next_map (committed_next)
  );

endmodule

// File: rtl/prr_reclaim_checker.sv
module prr_reclaim_checker #(
  parameter int unsigned NARCH = 32,
  parameter int unsigned NPHYS = 96,
  parameter int unsigned LANES = 4,
  localparam int unsigned DEPTH = NPHYS - NARCH,
  localparam int unsigned TW = $clog2(NPHYS),
  localparam int unsigned CW = $clog2(LANES + 1),
  localparam int unsigned PW = $clog2(DEPTH + 1)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                alloc_valid,
  input logic                alloc_ready,
  input logic [CW-1:0]       alloc_cnt,
  input logic [LANES*TW-1:0] alloc_new_tags,
  input logic                pool_empty,
  input logic [PW-1:0]       free_count,
  input logic                commit_valid,
  input logic                flush
);

  logic fire;
  logic started;
  assign fire = alloc_valid && alloc_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) started <= 1'b0;
    else        started <= 1'b1;
  end

  assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    int'(free_count) <= DEPTH);

  assert_no_overgrant_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> int'(alloc_cnt) <= int'(free_count));

  assert_empty_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pool_empty && alloc_cnt != '0) |-> !alloc_ready);

  assert_count_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (started && !flush) |=> int'(free_count) ==
      $past(int'(free_count)) - $past(fire ? int'(alloc_cnt) : 0)
      + $past(commit_valid ? 1 : 0));

  assert_flush_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !alloc_ready);

  assert_flush_refill_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> int'(free_count) == DEPTH);

  assert_commit_owner_R7: assert property (@(posedge clk) disable iff (!rst_n)
    commit_valid |-> int'(free_count) < DEPTH);

  for (genvar i = 0; i < LANES; i++) begin : g_a
    for (genvar j = i + 1; j < LANES; j++) begin : g_b
      assert_distinct_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && int'(alloc_cnt) > j) |->
          alloc_new_tags[i*TW +: TW] != alloc_new_tags[j*TW +: TW]);
    end
  end

endmodule

bind prr_reclaim_unit prr_reclaim_checker #(
  .NARCH(NARCH), .NPHYS(NPHYS), .LANES(LANES)
) u_chk (.*);

// File: tb/prr_reclaim_unit_bench.sv
`timescale 1ns/1ps
module prr_reclaim_unit_bench;
  localparam int NARCH = 32, NPHYS = 96, LANES = 4;
  localparam int DEPTH = NPHYS - NARCH;
  localparam int TW = $clog2(NPHYS), AW = $clog2(NARCH);
  localparam int CW = $clog2(LANES + 1), PW = $clog2(DEPTH + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic alloc_valid = 1'b0, alloc_ready;
  logic [CW-1:0] alloc_cnt = '0;
  logic [LANES*AW-1:0] alloc_arch = '0;
  logic [LANES*TW-1:0] alloc_new_tags, alloc_old_tags;
  logic pool_empty;
  logic [PW-1:0] free_count;
  logic commit_valid = 1'b0;
  logic [AW-1:0] commit_arch = '0;
  logic [TW-1:0] commit_new_tag = '0, commit_old_tag = '0;
  logic flush = 1'b0;
  logic [AW-1:0] map_rd_arch = '0;
  logic [TW-1:0] map_rd_tag;

  always #2.5 clk = ~clk;

  prr_reclaim_unit u_prr_reclaim_unit (.*);

  typedef struct { int arch; int nt; int ot; } rec_t;
  int smap [NARCH];
  int cmap [NARCH];
  int freeq[$];
  rec_t fly[$];
  int exp_new[$], exp_old[$];
  int total = 0, bad = 0;
  string scen = "R1";
  bit done = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Monitor: compares granted and displaced tags against the scoreboard
  always @(negedge clk) begin
    if (rst_n && alloc_valid && alloc_ready) begin
      for (int k = 0; k < int'(alloc_cnt); k++) begin
        if (exp_new.size() == 0) begin
          check(0, scen, "unexpected grant", k, -1);
        end else begin
          int en, eo;
          en = exp_new.pop_front();
          eo = exp_old.pop_front();
          check(int'(alloc_new_tags[k*TW +: TW]) == en, scen, "new tag",
                int'(alloc_new_tags[k*TW +: TW]), en);
          check(int'(alloc_old_tags[k*TW +: TW]) == eo, scen, "old tag",
                int'(alloc_old_tags[k*TW +: TW]), eo);
        end
      end
    end
  end

  // Driver: one cycle, entered and left at posedge+1
  task automatic step(input int cnt, input int a0, input int a1, input int a2,
                      input int a3, input bit do_alloc, input bit do_commit,
                      input bit do_flush);
    int arch[4];
    bit exp_ready;
    rec_t c;
    arch = '{a0, a1, a2, a3};
    exp_ready = !do_flush && cnt <= LANES && cnt <= freeq.size();
    alloc_valid = do_alloc;
    alloc_cnt = CW'(cnt);
    for (int k = 0; k < LANES; k++) alloc_arch[k*AW +: AW] = AW'(arch[k]);
    flush = do_flush;
    if (do_commit) begin
      c = fly.pop_front();
      commit_valid = 1'b1;
      commit_arch = AW'(c.arch);
      commit_new_tag = TW'(c.nt);
      commit_old_tag = TW'(c.ot);
    end
    if (do_alloc && exp_ready) begin
      for (int k = 0; k < cnt; k++) begin
        rec_t r;
        r.arch = arch[k];
        r.nt = freeq.pop_front();
        r.ot = smap[arch[k]];
        smap[arch[k]] = r.nt;
        exp_new.push_back(r.nt);
        exp_old.push_back(r.ot);
        fly.push_back(r);
      end
    end
    if (do_commit) begin
      cmap[c.arch] = c.nt;
      freeq.push_back(c.ot);
    end
    if (do_flush) begin
      for (int i = 0; i < NARCH; i++) smap[i] = cmap[i];
      for (int i = fly.size() - 1; i >= 0; i--) freeq.push_front(fly[i].nt);
      fly.delete();
    end
    @(negedge clk);
    if (do_alloc)
      check(alloc_ready == exp_ready, exp_ready ? scen : "R3", "alloc_ready",
            int'(alloc_ready), int'(exp_ready));
    @(posedge clk);
    #1;
    alloc_valid = 1'b0;
    commit_valid = 1'b0;
    flush = 1'b0;
    check(int'(free_count) == freeq.size(), scen, "free_count",
          int'(free_count), freeq.size());
    check(pool_empty == (freeq.size() == 0), "R3", "pool_empty",
          int'(pool_empty), int'(freeq.size() == 0));
  endtask

  task automatic check_map(input string req);
    for (int a = 0; a < NARCH; a++) begin
      map_rd_arch = AW'(a);
      #0.1;
      check(int'(map_rd_tag) == cmap[a], req, "committed map",
            int'(map_rd_tag), cmap[a]);
    end
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NARCH; i++) begin smap[i] = i; cmap[i] = i; end
    for (int i = 0; i < DEPTH; i++) freeq.push_back(NARCH + i);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk);
    #1;

    // R1: reset state
    check(int'(free_count) == DEPTH, "R1", "reset free_count", int'(free_count), DEPTH);
    check(pool_empty == 1'b0, "R1", "reset pool_empty", int'(pool_empty), 0);
    check_map("R1");

    // R2 / R4: first grants come from the architectural count upward
    scen = "R2";
    step(4, 1, 2, 3, 4, 1, 0, 0);
    // R5: two lanes on register 5 in one bundle, then a later rename
    scen = "R5";
    step(3, 5, 5, 6, 0, 1, 0, 0);
    step(1, 5, 0, 0, 0, 1, 0, 0);
    scen = "R4";
    step(2, 1, 9, 0, 0, 1, 0, 0);
    // R6: renaming never raises the free count
    check(int'(free_count) == DEPTH - 10, "R6", "free after renames",
          int'(free_count), DEPTH - 10);

    // R7: commits return displaced tags and update the committed map
    scen = "R7";
    step(0, 0, 0, 0, 0, 0, 1, 0);
    step(0, 0, 0, 0, 0, 0, 1, 0);
    check_map("R7");

    // R10: allocation and commit in the same cycle
    scen = "R10";
    step(2, 3, 3, 0, 0, 1, 1, 0);

    // R8: flush with a commit in the same cycle; bundle offered is refused
    scen = "R8";
    step(2, 1, 2, 0, 0, 1, 1, 1);
    check(int'(free_count) == DEPTH, "R8", "free after flush", int'(free_count), DEPTH);
    step(4, 1, 5, 7, 3, 1, 0, 0);
    step(4, 5, 5, 5, 5, 1, 0, 0);

    // R3: exhaust the pool, then refuse oversize and any request
    scen = "R3";
    step(5, 0, 0, 0, 0, 1, 0, 0);
    while (freeq.size() >= 4) begin
      int b;
      b = fly.size();
      step(4, (b * 3) % NARCH, (b * 3 + 7) % NARCH, (b * 5 + 1) % NARCH,
           (b * 3) % NARCH, 1, 0, 0);
    end
    step(4, 2, 4, 6, 8, 1, 0, 0);
    step(freeq.size(), 10, 11, 12, 13, 1, 0, 0);
    check(pool_empty == 1'b1, "R3", "pool empty at exhaustion", int'(pool_empty), 1);
    step(1, 3, 0, 0, 0, 1, 0, 0);

    // R9: drain every in-flight instruction, with one allocation mixed in
    scen = "R9";
    step(0, 0, 0, 0, 0, 0, 1, 0);
    step(1, 14, 0, 0, 0, 1, 1, 0);
    while (fly.size() > 0) step(0, 0, 0, 0, 0, 0, 1, 0);
    check(int'(free_count) == DEPTH, "R9", "free after drain", int'(free_count), DEPTH);
    check_map("R9");
    // Reuse order after the drain follows commit order
    step(4, 1, 2, 3, 4, 1, 0, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule